// File: doc/BRIEF.md
# Two-Stage Rotating Cell Switch

This block moves fixed-width cells between `N_PORTS` external inputs and `N_PORTS` external outputs. Each cell carries a valid bit, a destination output index and a payload. The block has no scheduler and no arbitration. A slot counter advances every clock. In each slot a first rotating stage joins every input to one middle port, and a second rotating stage joins every middle port to one output. The connection pattern changes by one position per slot, so across every `N_PORTS` slots each input meets each middle port exactly once, and each middle port meets each output exactly once.

The first stage spreads arriving cells over the middle ports and does not look at their destination. Each middle port keeps one FIFO per output. A cell that reaches a middle port is queued by its destination. When the second stage joins that middle port to output `o`, the head of the queue for `o` leaves, and it appears on the output one clock later. Because no path is ever contended, one middle-to-output link carries at most one cell in `N_PORTS` slots on average. This also means that cells of one flow may leave out of order. If a queue is full, the arriving cell is discarded and that middle port's drop counter is incremented.

Top module: `cyc_shift_switch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all `out_valid` bits are 0, every drop counter is 0 and the slot index is 0.
- R2: The slot index counts 0, 1, …, `N_PORTS`-1 and then returns to 0. It advances on every clock edge after reset.
- R3: In slot t, a cell at input i goes to middle port (i + t) mod `N_PORTS`, whatever its destination field holds.
- R4: Each middle port keeps one FIFO of `QUEUE_DEPTH` cells per destination. Cells that reach the same middle port for the same destination leave in the order they arrived.
- R5: In slot t, middle port m serves output (m + t) mod `N_PORTS` with the head of its queue for that output. The cell is on `out_valid`/`out_data` of that output in the cycle after slot t.
- R6: If the queue served in slot t is empty, the matching output has `out_valid` low in the next cycle.
- R7: A cell whose queue is full is discarded, and the drop counter of that middle port increases by exactly 1. The exception is a queue that is also served in the same slot: that queue accepts the cell.
- R8: A drop counter stops at its all-ones value and stays there.
- R9: Port k uses bits [k*W +: W] of each packed bus. W is `DEST_W` (= clog2 `N_PORTS`) for `in_dest`, `CELL_W` for the data buses and `DROP_W` for `drop_count`. For `drop_count`, k is the middle-port index. A destination value d selects output d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with `clk` |
| in_valid | input | N_PORTS | Cell present on input k |
| in_dest | input | N_PORTS*DEST_W | Destination output index per input |
| in_data | input | N_PORTS*CELL_W | Payload per input |
| out_valid | output | N_PORTS | Cell present on output k |
| out_data | output | N_PORTS*CELL_W | Payload per output, held while not valid |
| drop_count | output | N_PORTS*DROP_W | Saturating discard count per middle port |

## Verification
The assertions take for granted that every destination field with its valid bit set names an existing output (below `N_PORTS`). They also assume that reset is released away from the rising clock edge. The stimulus meets both conditions. Destinations are drawn modulo the port count. Reset is released on a falling edge. The random traffic runs heavily loaded so that queues fill, serve and overflow within one slot. A directed flood toward a single output drives every drop counter to saturation.

// File: rtl/cs_pkg.sv
package cs_pkg;

  // (a + b) mod n for operands already below n
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // (a - b) mod n for operands already below n
  function automatic int unsigned wrap_sub(int unsigned a, int unsigned b, int unsigned n);
    return (a >= b) ? a - b : a + n - b;
  endfunction

endpackage

// File: rtl/cs_slot_ctr.sv
module cs_slot_ctr #(
  parameter  int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] slot
);

  logic [W-1:0] slot_q;
  logic [W-1:0] slot_d;

  always_comb begin
    if (slot_q == W'(N - 1)) slot_d = '0;
    else                     slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == W'(N - 1)) |=> (slot_q == '0));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != W'(N - 1)) |=> (slot_q == W'($past(slot_q) + 1'b1)));

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= W'(N - 1));

endmodule

// File: rtl/cs_fifo.sv
module cs_fifo #(
  parameter  int DEPTH = 4,
  parameter  int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // storage has no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/cs_mid_port.sv
module cs_mid_port
  import cs_pkg::*;
#(
  parameter  int N      = 4,
  parameter  int PORT   = 0,
  parameter  int PW     = 8,
  parameter  int DEPTH  = 4,
  parameter  int DROP_W = 8,
  localparam int DW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     slot,
  input  logic              cell_valid,
  input  logic [DW-1:0]     cell_dest,
  input  logic [PW-1:0]     cell_data,
  output logic              srv_valid,
  output logic [PW-1:0]     srv_data,
  output logic [DROP_W-1:0] drop_cnt
);

  logic [N-1:0]      q_push, q_pop, q_empty, q_full;
  logic [PW-1:0]     q_head [N];
  logic [DW-1:0]     srv_dest;
  logic              drop_evt;
  logic [DROP_W-1:0] drop_q, drop_d;

  // output this middle port faces in the current slot
  always_comb begin
    srv_dest = DW'(wrap_add(PORT, int'(slot), N));
  end

  always_comb begin
    for (int d = 0; d < N; d++) begin
      q_pop[d]  = (srv_dest == DW'(d)) && !q_empty[d];
      q_push[d] = cell_valid && (cell_dest == DW'(d)) && (!q_full[d] || q_pop[d]);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_queue
    cs_fifo #(
      .DEPTH (DEPTH),
      .WIDTH (PW)
    ) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[g]),
      .pop   (q_pop[g]),
      .wdata (cell_data),
      .rdata (q_head[g]),
      .empty (q_empty[g]),
      .full  (q_full[g])
    );
  end

  assign srv_valid = !q_empty[srv_dest];
  assign srv_data  = q_head[srv_dest];

  always_comb begin
    drop_evt = cell_valid && q_full[cell_dest] && !q_pop[cell_dest];
    drop_d   = (drop_q == '1) ? drop_q : drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        drop_q <= '0;
    else if (drop_evt) drop_q <= drop_d;
  end

  assign drop_cnt = drop_q;

  assert_drop_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q == '1) |=> (drop_q == '1));

  assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    DROP_W'(drop_q - $past(drop_q)) <= DROP_W'(1));

  assert_one_serve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop));

  assert_dest_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (int'(cell_dest) < N));

endmodule

// File: rtl/cyc_shift_switch.sv
module cyc_shift_switch
  import cs_pkg::*;
#(
  parameter  int N_PORTS     = 4,
  parameter  int CELL_W      = 8,
  parameter  int QUEUE_DEPTH = 4,
  parameter  int DROP_W      = 8,
  localparam int DEST_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          in_valid,
  input  logic [N_PORTS*DEST_W-1:0]   in_dest,
  input  logic [N_PORTS*CELL_W-1:0]   in_data,
  output logic [N_PORTS-1:0]          out_valid,
  output logic [N_PORTS*CELL_W-1:0]   out_data,
  output logic [N_PORTS*DROP_W-1:0]   drop_count
);

  logic [DEST_W-1:0]  slot;
  logic [N_PORTS-1:0] mid_valid;
  logic [DEST_W-1:0]  mid_dest [N_PORTS];
  logic [CELL_W-1:0]  mid_data [N_PORTS];
  logic [N_PORTS-1:0] srv_valid;
  logic [CELL_W-1:0]  srv_data [N_PORTS];
  logic [N_PORTS-1:0] ov_d, ov_q;
  logic [CELL_W-1:0]  od_d [N_PORTS];
  logic [CELL_W-1:0]  od_q [N_PORTS];

  cs_slot_ctr #(.N(N_PORTS)) i_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot)
  );

  // first stage: middle m listens to input (m - t) mod N
  always_comb begin
    for (int m = 0; m < N_PORTS; m++) begin
      int unsigned src;
      src          = wrap_sub(m, int'(slot), N_PORTS);
      mid_valid[m] = in_valid[src];
      mid_dest[m]  = in_dest[src*DEST_W +: DEST_W];
      mid_data[m]  = in_data[src*CELL_W +: CELL_W];
    end
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_mid
    cs_mid_port #(
      .N      (N_PORTS),
      .PORT   (g),
      .PW     (CELL_W),
      .DEPTH  (QUEUE_DEPTH),
      .DROP_W (DROP_W)
    ) i_mid (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot       (slot),
      .cell_valid (mid_valid[g]),
      .cell_dest  (mid_dest[g]),
      .cell_data  (mid_data[g]),
      .srv_valid  (srv_valid[g]),
      .srv_data   (srv_data[g]),
      .drop_cnt   (drop_count[g*DROP_W +: DROP_W])
    );
  end

  // second stage: output o listens to middle (o - t) mod N
  always_comb begin
    for (int o = 0; o < N_PORTS; o++) begin
      int unsigned mp;
      mp      = wrap_sub(o, int'(slot), N_PORTS);
      ov_d[o] = srv_valid[mp];
      od_d[o] = srv_data[mp];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= '0;
    else        ov_q <= ov_d;
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (ov_d[g]) od_q[g] <= od_d[g];
    end
    assign out_data[g*CELL_W +: CELL_W] = od_q[g];
  end

  assign out_valid = ov_q;

  assert_out_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $past($countones(srv_valid)));

  assert_spread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mid_valid) == $countones(in_valid));

endmodule

// File: tb/test_cyc_shift_switch.sv
module test_cyc_shift_switch;

  localparam int NP   = 4;
  localparam int DSW  = 2;
  localparam int CW   = 8;
  localparam int QD   = 4;
  localparam int DRW  = 8;
  localparam int DMAX = (1 << DRW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NP-1:0]        in_valid;
  logic [NP*DSW-1:0]    in_dest;
  logic [NP*CW-1:0]     in_data;
  logic [NP-1:0]        out_valid;
  logic [NP*CW-1:0]     out_data;
  logic [NP*DRW-1:0]    drop_count;

  cyc_shift_switch #(
    .N_PORTS     (NP),
    .CELL_W      (CW),
    .QUEUE_DEPTH (QD),
    .DROP_W      (DRW)
  ) i_cyc_shift_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_dest    (in_dest),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .drop_count (drop_count)
  );

  always #10 clk = ~clk;

  // stimulus for the next slot
  logic         s_v [NP];
  int           s_d [NP];
  logic [CW-1:0] s_p [NP];

  // reference model
  logic [CW-1:0] mq [NP][NP][QD];
  int            mcnt [NP][NP];
  int            mdrop [NP];
  logic          ev [NP];
  logic [CW-1:0] ed [NP];
  int            t;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  function automatic int mid_of(input int i, input int slot);
    return (i + slot) % NP;
  endfunction

  function automatic int out_of(input int m, input int slot);
    return (m + slot) % NP;
  endfunction

  task automatic clear_stim();
    for (int i = 0; i < NP; i++) begin
      s_v[i] = 1'b0; s_d[i] = 0; s_p[i] = '0;
    end
  endtask

  // one slot: drive at negedge, update model, compare after the edge
  task automatic step(input string tag);
    for (int i = 0; i < NP; i++) begin
      in_valid[i]             = s_v[i];
      in_dest[i*DSW +: DSW]   = DSW'(s_d[i]);
      in_data[i*CW +: CW]     = s_p[i];
    end
    for (int m = 0; m < NP; m++) begin
      int o;
      o = out_of(m, t);
      if (mcnt[m][o] > 0) begin
        ev[o] = 1'b1;
        ed[o] = mq[m][o][0];
        for (int k = 0; k < QD - 1; k++) mq[m][o][k] = mq[m][o][k+1];
        mcnt[m][o]--;
      end else begin
        ev[o] = 1'b0;
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (s_v[i]) begin
        int m;
        m = mid_of(i, t);
        if (mcnt[m][s_d[i]] < QD) begin
          mq[m][s_d[i]][mcnt[m][s_d[i]]] = s_p[i];
          mcnt[m][s_d[i]]++;
        end else if (mdrop[m] < DMAX) begin
          mdrop[m]++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int o = 0; o < NP; o++) begin
      check(tag, $sformatf("out_valid[%0d]", o), int'(out_valid[o]), int'(ev[o]));
      if (ev[o]) check(tag, $sformatf("out_data[%0d]", o), int'(out_data[o*CW +: CW]), int'(ed[o]));
    end
    for (int m = 0; m < NP; m++)
      check(tag, $sformatf("drop_count[%0d]", m), int'(drop_count[m*DRW +: DRW]), mdrop[m]);
    t = (t + 1) % NP;
  endtask

  task automatic idle(input string tag, input int n);
    clear_stim();
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    in_valid = '0; in_dest = '0; in_data = '0;
    for (int m = 0; m < NP; m++) begin
      mdrop[m] = 0;
      for (int d = 0; d < NP; d++) mcnt[m][d] = 0;
    end
    t = 0;
    clear_stim();
    repeat (3) @(posedge clk);
    // R1: outputs quiet under reset
    #1;
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "drop_count in reset", int'(drop_count), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R5: single cell, input 1 to output 2 at slot 0 -> middle 1, served in slot 1
    clear_stim();
    s_v[1] = 1'b1; s_d[1] = 2; s_p[1] = 8'hA5;
    step("R1 R3");
    check("R1", "out_valid first cycle", int'(out_valid), 0);
    clear_stim();
    step("R3 R5");
    check("R3 R5", "hand out_valid", int'(out_valid), 4'b0100);
    check("R3 R5 R9", "hand out_data[2]", int'(out_data[2*CW +: CW]), 8'hA5);
    idle("R6", 6);

    // R4: four cells for output 2 all landing on middle 0, in order
    for (int k = 0; k < 4; k++) begin
      clear_stim();
      s_v[(NP - t) % NP] = 1'b1;
      s_d[(NP - t) % NP] = 2;
      s_p[(NP - t) % NP] = CW'(8'h10 + k);
      step("R4");
    end
    idle("R4 R6", 20);

    // R7 R8: flood output 0 from all inputs until counters saturate
    for (int k = 0; k < 420; k++) begin
      for (int i = 0; i < NP; i++) begin
        s_v[i] = 1'b1; s_d[i] = 0; s_p[i] = CW'($urandom);
      end
      step("R7 R8");
    end
    for (int m = 0; m < NP; m++)
      check("R8", $sformatf("drop_count[%0d] saturated", m), int'(drop_count[m*DRW +: DRW]), DMAX);
    idle("R6 R8", 20);

    // R2 R5 R6 R7: heavy random traffic across many slot wraps
    for (int k = 0; k < 2000; k++) begin
      for (int i = 0; i < NP; i++) begin
        s_v[i] = ($urandom % 4) != 0;
        s_d[i] = int'($urandom % NP);
        s_p[i] = CW'($urandom);
      end
      step("R2 R5 R6 R7");
    end
    idle("R4 R6", 24);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule